// File: doc/BRIEF.md
# Audio-Frame Heartbeat Driver

This block produces a slow square-wave heartbeat for an open-drain pin, so that an external supervisor or microcontroller can tell that the audio processing path is still running. Its time base is the stream of completed stereo frames from the serial audio port, not a free-running clock. Every `FRAMES_PER_HALF` frame strobes, it inverts an internal level. With the default of 4096 frames at a 48 kHz frame rate, one full heartbeat cycle lasts about 170.7 ms. If the audio interface stops delivering frames, the heartbeat freezes, and the supervisor sees the stall.

The pin itself is never driven high. The block either pulls the line low or releases it, and an external pull-up supplies the high level. While reset is applied, or while `en` is low, the line is released. When `en` rises, or when reset ends, the frame count restarts from zero. The internal level is also brought out as a status bit, so that the heartbeat can be observed without modelling the pull-up.

Top module: `audio_heartbeat`

## Requirements
- R1: A clock edge with `rst` high leaves `wd_oe`=0, `wd_pull_low`=0 and `wd_level`=1 (released) after that edge.
- R2: `wd_oe` goes to 1 two clock edges after `en` is first sampled high. It goes to 0 two clock edges after `en` is first sampled low.
- R3: With the block enabled, `wd_level` inverts on the edge that samples the `FRAMES_PER_HALF`-th counted strobe, and holds at every strobe before it.
- R4: `wd_pull_low` is 1 exactly when the block is active and `wd_level` is 0. It follows `wd_level` one edge later and is never 1 while `wd_oe` is 0.
- R5: Only the number of counted strobes sets the toggle point. Idle cycles between strobes have no effect.
- R6: With no strobes arriving, `wd_level` holds its value indefinitely.
- R7: While `en` is low, strobes are not counted, `wd_level` and the count stay frozen, and the line is released (`wd_oe`=0, `wd_pull_low`=0).
- R8: On the cycle where `en` goes from 0 to 1, the count restarts from zero and `wd_level` returns to 1.
- R9: A reset in mid-count discards the partial count. After release, a full `FRAMES_PER_HALF` strobes are again needed for the next toggle.
- R10: A strobe that arrives in the same cycle as the rise of `en` is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle pulse per completed stereo frame |
| en | input | 1 | Heartbeat enable |
| wd_pull_low | output | 1 | 1 = pull the open-drain line low |
| wd_oe | output | 1 | 1 = block active; 0 = line released (high impedance) |
| wd_level | output | 1 | Status: internal heartbeat level (1 = released phase) |

## Verification
- `wd_level` is registered once from the strobe. Its new value is due at the falling edge after the rising edge that samples the strobe. The scoreboard monitor therefore compares each queued expectation just after that falling edge.
- `wd_pull_low` adds one more register stage, so it is checked one falling edge later.
- `wd_oe` passes through two registers from `en`, so it is checked two falling edges after `en` changes.
- The idle, disabled and reset-in-mid-count phases use the same sampling points. Each expectation is taken from a frame count that the bench keeps itself.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic {
    HB_LVL_LOW  = 1'b0,
    HB_LVL_HIGH = 1'b1
  } hb_level_e;

  function automatic int unsigned hb_cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hb_frame_counter.sv
module hb_frame_counter
  import hb_pkg::*;
#(
  parameter int unsigned HALF_FRAMES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic en,
  output logic level,
  output logic active,
  output logic at_last
);
  localparam int unsigned CW = hb_cnt_width(HALF_FRAMES);
  localparam logic [CW-1:0] LAST = CW'(HALF_FRAMES - 1);

  logic [CW-1:0] cnt;
  logic          en_q;
  logic          rise;
  hb_level_e     lvl;

  assign rise    = en & ~en_q;
  assign at_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      en_q <= 1'b0;
      lvl  <= HB_LVL_HIGH;
    end else begin
      en_q <= en;
      if (rise) begin
        cnt <= '0;
        lvl <= HB_LVL_HIGH;
      end else if (en && stb) begin
        if (at_last) begin
          cnt <= '0;
          lvl <= (lvl == HB_LVL_HIGH) ? HB_LVL_LOW : HB_LVL_HIGH;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign level  = lvl;
  assign active = en_q;
endmodule

// File: rtl/hb_od_stage.sv
module hb_od_stage (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic level,
  output logic oe,
  output logic pull_low
);
  always_ff @(posedge clk) begin
    if (rst) begin
      oe       <= 1'b0;
      pull_low <= 1'b0;
    end else begin
      oe       <= active;
      pull_low <= active & ~level;
    end
  end
endmodule

// File: rtl/audio_heartbeat.sv
module audio_heartbeat #(
  parameter int unsigned FRAMES_PER_HALF = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  input  logic en,
  output logic wd_pull_low,
  output logic wd_oe,
  output logic wd_level
);
  logic active;
  logic at_last;

  hb_frame_counter #(.HALF_FRAMES(FRAMES_PER_HALF)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .stb     (frame_stb),
    .en      (en),
    .level   (wd_level),
    .active  (active),
    .at_last (at_last)
  );

  hb_od_stage u_od (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .level    (wd_level),
    .oe       (wd_oe),
    .pull_low (wd_pull_low)
  );
endmodule

// File: rtl/audio_heartbeat_chk.sv
module audio_heartbeat_chk (
  input logic clk,
  input logic rst,
  input logic frame_stb,
  input logic en,
  input logic active,
  input logic at_last,
  input logic wd_pull_low,
  input logic wd_oe,
  input logic wd_level
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!wd_oe && !wd_pull_low && wd_level));

  // R2
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    active |=> wd_oe);

  // R7
  released_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!wd_oe && !wd_pull_low));

  // R4
  pull_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
    wd_pull_low |-> wd_oe);

  // R4
  pull_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !wd_level) |=> wd_pull_low);

  // R3
  toggle_at_last_chk: assert property (@(posedge clk) disable iff (rst)
    (en && active && frame_stb && at_last) |=> (wd_level != $past(wd_level)));

  // R6
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (en && active && !frame_stb) |=> $stable(wd_level));

  // R7
  frozen_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(wd_level));
endmodule

bind audio_heartbeat audio_heartbeat_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_stb   (frame_stb),
  .en          (en),
  .active      (active),
  .at_last     (at_last),
  .wd_pull_low (wd_pull_low),
  .wd_oe       (wd_oe),
  .wd_level    (wd_level)
);

// File: tb/tb_audio_heartbeat.sv
module tb_audio_heartbeat;
  localparam int unsigned N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0;
  logic en = 1'b0;
  logic wd_pull_low, wd_oe, wd_level;

  always #2.5 clk = ~clk;

  audio_heartbeat #(.FRAMES_PER_HALF(N)) dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .en(en),
    .wd_pull_low(wd_pull_low), .wd_oe(wd_oe), .wd_level(wd_level)
  );

  typedef struct {
    logic  lvl;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  int   m_cnt = 0;
  logic m_lvl = 1'b1;
  bit   m_en  = 1'b0;

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  // monitor: compares queued level expectations just after each falling edge
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(wd_level === e.lvl, e.req, wd_level, e.lvl);
    end
  end

  // driver: one strobe, then push the expected level
  task automatic frame(input string req, input int gap);
    @(negedge clk);
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    if (m_en) begin
      m_cnt++;
      if (m_cnt == N) begin
        m_cnt = 0;
        m_lvl = ~m_lvl;
      end
    end
    exp_q.push_back('{lvl: m_lvl, req: req});
    repeat (gap) @(negedge clk);
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    en = v;
    if (v && !m_en) begin
      m_cnt = 0;
      m_lvl = 1'b1;
    end
    m_en = v;
  endtask

  task automatic chk_pins(input string req, input logic oe_e, input logic pl_e);
    #1;
    check(wd_oe === oe_e, {req, " oe"}, wd_oe, oe_e);
    check(wd_pull_low === pl_e, {req, " pull"}, wd_pull_low, pl_e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_pins("R1", 1'b0, 1'b0);
    exp_q.push_back('{lvl: 1'b1, req: "R1 level"});
    @(negedge clk);
    rst = 1'b0;

    // R2 enable -> oe after two edges
    set_en(1'b1);
    @(negedge clk);
    chk_pins("R2 early", 1'b0, 1'b0);
    @(negedge clk);
    chk_pins("R2", 1'b1, 1'b0);

    // R3 toggle on the N-th strobe; R4 pull follows one edge later
    for (int i = 0; i < N; i++) frame("R3", 0);
    @(negedge clk);
    chk_pins("R4 low phase", 1'b1, 1'b1);

    // R5 spaced strobes toggle after the same count
    for (int i = 0; i < N; i++) frame("R5", i % 3);
    @(negedge clk);
    chk_pins("R5 pull", 1'b1, 1'b0);

    // R6 no strobes: level holds
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      exp_q.push_back('{lvl: m_lvl, req: "R6 hold"});
    end

    // go low, partial count, then disable
    for (int i = 0; i < N; i++) frame("R3 second", 0);
    for (int i = 0; i < 3; i++) frame("R3 partial", 0);
    set_en(1'b0);
    @(negedge clk);
    @(negedge clk);
    chk_pins("R7 released", 1'b0, 1'b0);
    for (int i = 0; i < 2 * N; i++) frame("R7 frozen", 0);

    // R8 re-enable restarts count, level back to 1
    set_en(1'b1);
    @(negedge clk);
    exp_q.push_back('{lvl: 1'b1, req: "R8 level on rise"});
    for (int i = 0; i < N; i++) frame("R8 restart", 0);
    @(negedge clk);
    chk_pins("R8 pull", 1'b1, 1'b1);

    // R9 reset in mid-count
    for (int i = 0; i < 5; i++) frame("R9 partial", 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk_pins("R1 mid-run", 1'b0, 1'b0);
    exp_q.push_back('{lvl: 1'b1, req: "R1 mid-run level"});
    rst = 1'b0;
    m_cnt = 0;
    m_lvl = 1'b1;
    for (int i = 0; i < N; i++) frame("R9 full count", 0);

    // R10 strobe coincident with enable rise is not counted
    set_en(1'b0);
    repeat (3) @(negedge clk);
    en = 1'b1;
    frame_stb = 1'b1;
    m_en = 1'b1;
    m_cnt = 0;
    m_lvl = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    exp_q.push_back('{lvl: 1'b1, req: "R10 rise"});
    for (int i = 0; i < N; i++) frame("R10", 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule